// File: doc/BRIEF.md
# Windowed Watchdog Timer with Prescaler

This block supervises software by running a down-counter from a clock that is independent of the processor. A programmable prescaler divides that clock so the counter loses one count only every P watchdog-clock cycles. Software keeps the system alive by writing a fixed key to the feed register, which reloads the counter to its top value. The reload is honoured only when the counter has already fallen to or below a programmable window threshold. A feed that arrives too early, or a write of any other value to the feed register, is a fault.

Both a timeout and a fault follow the same path. An interrupt is raised while the counter sits at 1, and one prescaled step later a reset request is driven for a fixed number of watchdog-clock cycles. After that the block returns to its disabled power-on state. Register writes come from the bus clock domain. Each write crosses into the watchdog domain through a toggle handshake, and the bus side stays busy until the crossing has been acknowledged.

Top module: `win_watchdog`

## Requirements
- R1: After reset, `irq`, `rst_req` and `wr_busy` are low and the watchdog is disabled.
- R2: A write to address 0 (control) with bit 0 set enables the watchdog. Bits 3:1 give the prescaler select s, with P = 4·2^s for s = 0..6 and P = 256 for s = 7. The counter starts at its top value 2^CNT_W−1. `irq` goes high when the counter reaches 1, which is (2^CNT_W−2)·P watchdog cycles after the write lands. `rst_req` rises exactly P cycles after `irq`, and `irq` drops at that point.
- R3: `rst_req` stays high for exactly RST_CYC (default 4) watchdog cycles. The block then returns to its disabled reset state, with `irq` low, and can be enabled again.
- R4: A write of the key 16'hC35A to address 2 (feed) is a valid feed when the counter is at or below the window threshold. The threshold is written at address 1, low CNT_W bits, and defaults to the top value. A valid feed reloads the counter to the top value and restarts the prescaler. A valid feed made while `irq` is high clears `irq`, and no reset follows.
- R5: A key write to address 2 while the counter is above the window threshold is an early feed. It forces the counter to 1, so `irq` rises within a few cycles, and `rst_req` follows one prescaled step later. Any feed after a fault is ignored.
- R6: Writing any value other than the key to address 2 while enabled is a fault with the same behaviour as R5.
- R7: While enabled, a control write with bit 0 clear does not disable the watchdog.
- R8: A prescaler select written while running is stored. It is used only from the next reload, whether that reload is a valid feed or an enable.
- R9: A write is accepted only on a bus clock edge where `wr_en` is high and `wr_busy` is low. `wr_busy` is high from the next cycle until the watchdog domain acknowledges the write. A write presented while `wr_busy` is high is dropped.
- R10: While disabled, writes to the feed register have no effect: no interrupt and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock for register writes |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 window, 2 feed |
| wr_data | input | 16 | Write data |
| wr_busy | output | 1 | Previous write still crossing; new writes are dropped |
| wdg_clk | input | 1 | Independent watchdog clock |
| wdg_rst_n | input | 1 | Active-low reset, watchdog domain |
| irq | output | 1 | Early-warning interrupt, high while the counter is at 1 |
| rst_req | output | 1 | System reset request, high for RST_CYC watchdog cycles |

## Verification
Two functions can meet in one watchdog cycle: a feed landing from the crossing and the prescaled step that would take the counter from 1 to 0. The rule is that the feed wins and the counter is reloaded. The bench provokes the nearby case on purpose. It waits for `irq` with a long prescaler and then feeds, so the reload lands inside the final step. It judges the result by `irq` falling and by `rst_req` never rising in the following cycles. A second overlap is a feed arriving after a fault has already set the counter to 1. The bench sends the key right after the fault interrupt, and the reset must still arrive exactly one step after `irq`.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int DIV_W  = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_WIN  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FEED = 2'd2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_t;

    // terminal value of the prescale divider for select code sel
    function automatic logic [DIV_W-1:0] psc_limit(input logic [2:0] sel);
        logic [DIV_W:0] p;
        p = (sel == 3'd7) ? (DIV_W+1)'(256) : ((DIV_W+1)'(4) << sel);
        return DIV_W'(p - 1'b1);
    endfunction

endpackage

// File: rtl/wdg_cdc.sv
module wdg_cdc
    import wdg_pkg::*;
(
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_busy,
    input  logic              wdg_clk,
    input  logic              wdg_rst_n,
    output logic              evt_valid,
    output wr_t               evt
);

    typedef struct packed {
        logic req;
        logic ack1;
        logic ack2;
        wr_t  hold;
    } bus_st_t;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } wdg_st_t;

    bus_st_t b_d, b_q;
    wdg_st_t w_d, w_q;

    assign wr_busy = b_q.req ^ b_q.ack2;

    always_comb begin
        b_d      = b_q;
        b_d.ack1 = w_q.s3;
        b_d.ack2 = b_q.ack1;
        if (wr_en && !wr_busy) begin
            b_d.req       = ~b_q.req;
            b_d.hold.addr = wr_addr;
            b_d.hold.data = wr_data;
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) b_q <= '0;
        else            b_q <= b_d;
    end

    always_comb begin
        w_d.s1 = b_q.req;
        w_d.s2 = w_q.s1;
        w_d.s3 = w_q.s2;
    end

    always_ff @(posedge wdg_clk or negedge wdg_rst_n) begin
        if (!wdg_rst_n) w_q <= '0;
        else            w_q <= w_d;
    end

    // hold is stable for the whole time the toggle travels
    assign evt_valid = w_q.s2 ^ w_q.s3;
    assign evt       = b_q.hold;

endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [2:0] sel,
    output logic       step
);

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] lim;

    assign lim  = psc_limit(sel);
    assign step = run && !clear && (div_q == lim);

    always_comb begin
        div_d = div_q + 1'b1;
        if (!run || clear || div_q == lim) div_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int                CNT_W   = 16,
    parameter logic [DATA_W-1:0] KEY     = 16'hC35A,
    parameter int                RST_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_valid,
    input  wr_t        evt,
    input  logic       step,
    output logic       run,
    output logic       clear,
    output logic [2:0] sel_act,
    output logic       irq,
    output logic       rst_req,
    output logic       en
);

    localparam logic [CNT_W-1:0] TOP    = '1;
    localparam int               HOLD_W = $clog2(RST_CYC + 1);

    typedef enum logic [1:0] {M_IDLE, M_RUN, M_RST} mode_e;

    typedef struct packed {
        mode_e             mode;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  win;
        logic [2:0]        pend;
        logic [2:0]        act;
        logic              fault;
        logic [HOLD_W-1:0] hold;
    } state_t;

    localparam state_t RST_VAL = '{mode: M_IDLE, cnt: TOP, win: TOP, pend: 3'd0,
                                   act: 3'd0, fault: 1'b0, hold: '0};

    state_t s_d, s_q;
    logic   clr;

    always_comb begin
        s_d = s_q;
        clr = 1'b0;
        unique case (s_q.mode)
            M_IDLE: begin
                if (evt_valid && evt.addr == A_CTRL) begin
                    s_d.pend = evt.data[3:1];
                    if (evt.data[0]) begin
                        s_d.mode = M_RUN;
                        s_d.cnt  = TOP;
                        s_d.act  = evt.data[3:1];
                        clr      = 1'b1;
                    end
                end else if (evt_valid && evt.addr == A_WIN) begin
                    s_d.win = evt.data[CNT_W-1:0];
                end
            end
            M_RUN: begin
                if (step) begin
                    if (s_q.cnt == CNT_W'(1)) begin
                        s_d.mode = M_RST;
                        s_d.cnt  = '0;
                        s_d.hold = '0;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                if (evt_valid) begin
                    if (evt.addr == A_CTRL) begin
                        s_d.pend = evt.data[3:1];
                    end else if (evt.addr == A_WIN) begin
                        s_d.win = evt.data[CNT_W-1:0];
                    end else if (evt.addr == A_FEED && !s_q.fault) begin
                        // a feed overrides a step in the same cycle
                        s_d.mode = M_RUN;
                        clr      = 1'b1;
                        if (evt.data == KEY && s_q.cnt <= s_q.win) begin
                            s_d.cnt = TOP;
                            s_d.act = s_q.pend;
                        end else begin
                            s_d.fault = 1'b1;
                            s_d.cnt   = CNT_W'(1);
                        end
                    end
                end
            end
            default: begin
                if (s_q.hold == HOLD_W'(RST_CYC - 1)) s_d = RST_VAL;
                else                                  s_d.hold = s_q.hold + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_VAL;
        else        s_q <= s_d;
    end

    assign run     = (s_q.mode == M_RUN);
    assign clear   = clr;
    assign sel_act = s_q.act;
    assign irq     = (s_q.mode == M_RUN) && (s_q.cnt == CNT_W'(1));
    assign rst_req = (s_q.mode == M_RST);
    assign en      = (s_q.mode != M_IDLE);

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wdg_pkg::*;
#(
    parameter int                CNT_W   = 16,
    parameter logic [DATA_W-1:0] KEY     = 16'hC35A,
    parameter int                RST_CYC = 4
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_busy,
    input  logic              wdg_clk,
    input  logic              wdg_rst_n,
    output logic              irq,
    output logic              rst_req
);

    logic       evt_valid;
    wr_t        evt;
    logic       step;
    logic       core_run;
    logic       core_clear;
    logic [2:0] core_sel;
    logic       core_en;

    wdg_cdc cdc_i (
        .bus_clk   (bus_clk),
        .bus_rst_n (bus_rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_busy   (wr_busy),
        .wdg_clk   (wdg_clk),
        .wdg_rst_n (wdg_rst_n),
        .evt_valid (evt_valid),
        .evt       (evt)
    );

    wdg_prescale psc_i (
        .clk   (wdg_clk),
        .rst_n (wdg_rst_n),
        .run   (core_run),
        .clear (core_clear),
        .sel   (core_sel),
        .step  (step)
    );

    wdg_core #(
        .CNT_W   (CNT_W),
        .KEY     (KEY),
        .RST_CYC (RST_CYC)
    ) core_i (
        .clk       (wdg_clk),
        .rst_n     (wdg_rst_n),
        .evt_valid (evt_valid),
        .evt       (evt),
        .step      (step),
        .run       (core_run),
        .clear     (core_clear),
        .sel_act   (core_sel),
        .irq       (irq),
        .rst_req   (rst_req),
        .en        (core_en)
    );

endmodule

module wdg_chk #(
    parameter int RST_CYC = 4
) (
    input logic bus_clk,
    input logic bus_rst_n,
    input logic wr_en,
    input logic wr_busy,
    input logic wdg_clk,
    input logic wdg_rst_n,
    input logic irq,
    input logic rst_req,
    input logic en
);

    localparam int RW = $clog2(RST_CYC + 2);
    logic [RW-1:0] rst_len;

    always_ff @(posedge wdg_clk or negedge wdg_rst_n) begin
        if (!wdg_rst_n)   rst_len <= '0;
        else if (rst_req) rst_len <= rst_len + 1'b1;
        else              rst_len <= '0;
    end

    assert_irq_before_rst_R2: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
        $rose(rst_req) |-> $past(irq));

    assert_irq_rst_excl_R2: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
        rst_req |-> !irq);

    assert_rst_not_long_R3: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
        rst_req |-> (rst_len < RW'(RST_CYC)));

    assert_rst_full_len_R3: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
        $fell(rst_req) |-> (rst_len == RW'(RST_CYC)));

    assert_en_sticky_R7: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
        $fell(en) |-> $past(rst_req));

    assert_busy_after_accept_R9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_en && !wr_busy) |=> wr_busy);

endmodule

bind win_watchdog wdg_chk #(.RST_CYC(RST_CYC)) chk_i (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .wr_en     (wr_en),
    .wr_busy   (wr_busy),
    .wdg_clk   (wdg_clk),
    .wdg_rst_n (wdg_rst_n),
    .irq       (irq),
    .rst_req   (rst_req),
    .en        (core_en)
);

// File: tb/win_watchdog_tb_top.sv
module win_watchdog_tb_top;

    localparam int   CNT_W = 6;
    localparam int   TOPM1 = (1 << CNT_W) - 2;
    localparam logic [15:0] KEY = 16'hC35A;

    // prescaler sweep: {select, expected P}
    localparam logic [11:0] VEC [0:3] = '{ {3'd0, 9'd4}, {3'd2, 9'd16},
                                           {3'd5, 9'd128}, {3'd7, 9'd256} };

    logic bus_clk = 0, wdg_clk = 0;
    logic bus_rst_n = 0, wdg_rst_n = 0;
    logic wr_en = 0;
    logic [1:0] wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic wr_busy, irq, rst_req;

    int checks = 0, errors = 0;
    int wcyc = 0, rst_rises = 0;
    logic rst_prev = 0;

    always #10 bus_clk = ~bus_clk;
    always #15 wdg_clk = ~wdg_clk;

    always @(posedge wdg_clk) begin
        wcyc <= wcyc + 1;
        rst_prev <= rst_req;
        if (rst_req && !rst_prev) rst_rises <= rst_rises + 1;
    end

    win_watchdog #(.CNT_W(CNT_W), .KEY(KEY), .RST_CYC(4)) dut_i (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_busy(wr_busy), .wdg_clk(wdg_clk), .wdg_rst_n(wdg_rst_n),
        .irq(irq), .rst_req(rst_req));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        chk(act >= lo && act <= hi, tag, act, lo);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge bus_clk);
        while (wr_busy) @(negedge bus_clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge bus_clk);
        wr_en = 0;
    endtask

    task automatic wcycles(input int n);
        repeat (n) @(negedge wdg_clk);
    endtask

    task automatic wait_irq(input int tmo, output int dly);
        int t0 = wcyc;
        do @(negedge wdg_clk); while (!irq && (wcyc - t0) < tmo);
        dly = wcyc - t0;
    endtask

    task automatic wait_rst(input int tmo, output int dly);
        int t0 = wcyc;
        do @(negedge wdg_clk); while (!rst_req && (wcyc - t0) < tmo);
        dly = wcyc - t0;
    endtask

    task automatic drain();
        int d;
        wait_rst(20000, d);
        while (rst_req) @(negedge wdg_clk);
        wcycles(3);
    endtask

    initial begin
        repeat (190000) @(posedge bus_clk);
        errors++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d, t0, tf, ti, w, rr;
        repeat (4) @(posedge bus_clk);
        bus_rst_n = 1; wdg_rst_n = 1;
        wcycles(3);

        // R1 reset state
        chk(irq == 0, "R1 irq after reset", irq, 0);
        chk(rst_req == 0, "R1 rst_req after reset", rst_req, 0);
        chk(wr_busy == 0, "R1 wr_busy after reset", wr_busy, 0);

        // R10 feed ignored while disabled
        bus_write(2'd2, 16'h1234);
        wcycles(300);
        chk(irq == 0, "R10 irq after disabled feed", irq, 0);
        chk(rst_rises == 0, "R10 reset after disabled feed", rst_rises, 0);

        // R9 write while busy is dropped
        @(negedge bus_clk);
        wr_en = 1; wr_addr = 2'd1; wr_data = 16'd63;
        @(negedge bus_clk);
        chk(wr_busy == 1, "R9 busy after accept", wr_busy, 1);
        wr_addr = 2'd0; wr_data = 16'h0001;
        @(negedge bus_clk);
        wr_en = 0;
        wcycles(400);
        chk(irq == 0 && rst_rises == 0, "R9 enable while busy dropped", irq, 0);

        // R2/R3 prescaler sweep
        for (int i = 0; i < 4; i++) begin
            int p;
            p = int'(VEC[i][8:0]);
            bus_write(2'd0, {12'd0, VEC[i][11:9], 1'b1});
            wait_irq(70000, d);
            chk_rng("R2 enable to irq", d, TOPM1 * p - 1, TOPM1 * p + 6);
            wait_rst(600, d);
            chk(d == p, "R2 irq to rst_req", d, p);
            chk(irq == 0, "R2 irq low during reset", irq, 0);
            w = 0;
            while (rst_req) begin w++; @(negedge wdg_clk); end
            chk(w == 4, "R3 rst_req width", w, 4);
            wcycles(3);
            chk(irq == 0 && rst_req == 0, "R3 idle after reset", irq, 0);
        end

        // R6 wrong key
        bus_write(2'd0, 16'h0001);
        wcycles(20);
        bus_write(2'd2, 16'h1234);
        wait_irq(40, d);
        ti = wcyc;
        chk_rng("R6 wrong key to irq", d, 0, 8);
        wait_rst(40, d);
        chk(wcyc - ti == 4, "R6 irq to rst_req", wcyc - ti, 4);
        drain();

        // R5 early feed, later key ignored
        bus_write(2'd1, 16'd10);
        bus_write(2'd0, 16'h0005);
        bus_write(2'd2, KEY);
        wait_irq(40, d);
        ti = wcyc;
        chk_rng("R5 early feed to irq", d, 0, 10);
        bus_write(2'd2, KEY);
        wait_rst(60, d);
        chk(wcyc - ti == 16, "R5 feed after fault ignored", wcyc - ti, 16);
        drain();

        // R4 valid feed inside window
        bus_write(2'd1, 16'd40);
        bus_write(2'd0, 16'h0001);
        t0 = wcyc;
        rr = rst_rises;
        wcycles(130);
        bus_write(2'd2, KEY);
        tf = wcyc;
        wcycles(270 - (wcyc - t0));
        chk(irq == 0 && rst_rises == rr, "R4 no timeout after valid feed", irq, 0);
        wait_irq(600, d);
        chk_rng("R4 reload to top", wcyc - tf, TOPM1 * 4 - 1, TOPM1 * 4 + 6);
        drain();

        // R7/R8 sticky enable and deferred prescaler
        bus_write(2'd0, 16'h0001);
        t0 = wcyc;
        bus_write(2'd0, 16'h0006);
        wait_irq(3000, d);
        chk_rng("R7 R8 old prescaler kept, still enabled", wcyc - t0, TOPM1 * 4 - 1, TOPM1 * 4 + 6);
        drain();

        bus_write(2'd0, 16'h0001);
        bus_write(2'd0, 16'h0006);
        wcycles(100);
        chk(irq == 0, "R8 running before feed", irq, 0);
        bus_write(2'd2, KEY);
        tf = wcyc;
        wait_irq(3000, d);
        chk_rng("R8 new prescaler after reload", wcyc - tf, TOPM1 * 32 - 1, TOPM1 * 32 + 6);

        // R4 feed while irq high rescues
        rr = rst_rises;
        bus_write(2'd2, KEY);
        wcycles(40);
        chk(irq == 0, "R4 irq cleared by feed", irq, 0);
        chk(rst_rises == rr, "R4 reset avoided by feed", rst_rises, rr);
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule